// File: doc/BRIEF.md
# Interrupt Routing Table Register Window

This block is the software-visible register store of an I/O interrupt routing controller. A 32-bit bus slave sits in a 4 KB window and decodes two word offsets. The first holds an 8-bit selector byte. The second is a data port onto whichever internal register the selector names. Behind the data port are an identification register, a read-only revision word, and a table of routing entries. Each entry is 64 bits wide and is reached as two 32-bit halves at consecutive selector values.

Software first writes the selector. It then reads or writes the data port. A write to one half of an entry keeps the other half intact, so an entry is updated in two separate bus writes. The whole table is driven out in parallel on a flat vector, which the dispatch logic uses to see each entry's mask, vector and mode fields. Dispatch and base-address choice live elsewhere.

Top module: `irq_route_regs`

## Requirements
- R1: A write to offset 0x000 stores `bus_wdata[7:0]` as the selector. A read of offset 0x000 returns the selector in bits 7:0, with bits 31:8 zero.
- R2: `bus_ready` is always high. Every accepted read (`bus_valid` high with `bus_write` low) gives `rd_valid` high in exactly the next cycle, with `rd_data` valid in that same cycle. In a cycle after a write or an idle cycle, `rd_valid` is low.
- R3: With selector 0x00, a data-port write (offset 0x010) stores `bus_wdata[31:24]` as the identification byte. A data-port read returns that byte in bits 31:24, with bits 23:0 zero.
- R4: With selector 0x01, a data-port read returns 0x11 in bits 7:0 and the highest entry number (NUM_ENTRIES-1, 23 by default) in bits 23:16, with the other bits zero. A write there changes nothing.
- R5: Selector value s in 0x10 .. 0x10+2*NUM_ENTRIES-1 addresses entry n = (s-0x10)>>1. An even s reaches entry bits 31:0 and an odd s reaches bits 63:32, for both read and write.
- R6: A data-port write to one half of an entry leaves the other half of that entry, and every other entry, unchanged.
- R7: After reset every entry is 0x0000_0000_0001_0000 (only bit 16, the mask bit, set). The identification byte and the selector are zero.
- R8: With a selector that maps to no register (0x02..0x0F, or 0x10+2*NUM_ENTRIES and above), a data-port read returns zero and a data-port write changes no state.
- R9: An access to any offset other than 0x000 and 0x010 reads zero, and a write there changes neither the selector nor any register.
- R10: `entry_out[64n+63:64n]` carries entry n, and it shows a data-port write from the cycle after the write is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted (always high) |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| entry_out | output | 64*NUM_ENTRIES | All routing entries, entry n at bits 64n+63:64n |

## Verification
The hardest case to reach is a half-entry write that lands next to a half that already holds non-reset data. A stale or clobbered neighbour only shows up if both halves were written with different patterns first. So the stimulus runs hundreds of random selector/write/read rounds weighted toward the entry range, which fills many entries with random data on both halves before they are overwritten. Directed cases then cover the last entry, the first unmapped selector past the table, the gap at 0x02..0x0F, and stray bus offsets, each followed by a comparison of the exported table.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int unsigned SEL_W   = 8;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ENTRY_W = 64;
  localparam logic [SEL_W-1:0] TABLE_BASE = 8'h10;
  localparam logic [ENTRY_W-1:0] ENTRY_RESET = 64'h0000_0000_0001_0000;
  localparam logic [7:0] REVISION = 8'h11;

  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_SEL  = 2'd1,
    PORT_DATA = 2'd2
  } port_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_IDENT = 2'd1,
    TGT_REV   = 2'd2,
    TGT_ENTRY = 2'd3
  } target_e;

  // entry slot reached by a selector value (meaningful only for table range)
  function automatic logic [SEL_W-2:0] slot_of(input logic [SEL_W-1:0] sel);
    logic [SEL_W-1:0] off;
    off = sel - TABLE_BASE;
    return off[SEL_W-1:1];
  endfunction

  function automatic logic upper_half(input logic [SEL_W-1:0] sel);
    return sel[0];
  endfunction

  function automatic target_e classify(input logic [SEL_W-1:0] sel,
                                       input int unsigned n_entries);
    if (sel == 8'h00) return TGT_IDENT;
    if (sel == 8'h01) return TGT_REV;
    if (sel >= TABLE_BASE && int'(slot_of(sel)) < int'(n_entries)) return TGT_ENTRY;
    return TGT_NONE;
  endfunction

  function automatic logic [WORD_W-1:0] revision_word(input int unsigned n_entries);
    logic [7:0] top;
    top = 8'(n_entries - 1);
    return {8'h00, top, 8'h00, REVISION};
  endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_route_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] SEL_OFF  = 12'h000,
  parameter logic [ADDR_W-1:0] DATA_OFF = 12'h010
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output port_e             port,
  output logic              sel_wr,
  output logic              data_wr,
  output logic              rd_take
);
  always_comb begin
    if (bus_addr == SEL_OFF)       port = PORT_SEL;
    else if (bus_addr == DATA_OFF) port = PORT_DATA;
    else                           port = PORT_NONE;
  end

  assign sel_wr  = bus_valid &&  bus_write && (port == PORT_SEL);
  assign data_wr = bus_valid &&  bus_write && (port == PORT_DATA);
  assign rd_take = bus_valid && !bus_write;
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic              data_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [SEL_W-1:0]  sel_q,
  output logic [7:0]        ident_q,
  output target_e           target
);
  assign target = classify(sel_q, NUM_ENTRIES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      ident_q <= '0;
    end else begin
      if (sel_wr) sel_q <= wdata[SEL_W-1:0];
      if (data_wr && target == TGT_IDENT) ident_q <= wdata[31:24];
    end
  end
endmodule

// File: rtl/irq_entry_bank.sv
module irq_entry_bank
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [SEL_W-2:0]                    slot,
  input  logic                                upper,
  input  logic [WORD_W-1:0]                   wdata,
  output logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] entries
);
  localparam int unsigned HALF_W = ENTRY_W / 2;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (slot == (SEL_W-1)'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entries[e] <= ENTRY_RESET;
      end else if (hit) begin
        if (upper) entries[e][ENTRY_W-1:HALF_W] <= wdata;
        else       entries[e][HALF_W-1:0]       <= wdata;
      end
    end
  end
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                rd_take,
  input  port_e                               port,
  input  target_e                             target,
  input  logic [SEL_W-1:0]                    sel_q,
  input  logic [7:0]                          ident_q,
  input  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] entries,
  output logic                                rd_valid,
  output logic [WORD_W-1:0]                   rd_data
);
  logic [ENTRY_W-1:0] picked;
  logic [WORD_W-1:0]  data_word;
  logic [WORD_W-1:0]  next_word;
  logic [SEL_W-2:0]   slot;

  assign slot = slot_of(sel_q);

  always_comb begin
    picked = '0;
    for (int e = 0; e < int'(NUM_ENTRIES); e++) begin
      if (slot == (SEL_W-1)'(e)) picked = entries[e];
    end
  end

  always_comb begin
    unique case (target)
      TGT_IDENT: data_word = {ident_q, 24'h0};
      TGT_REV:   data_word = revision_word(NUM_ENTRIES);
      TGT_ENTRY: data_word = upper_half(sel_q) ? picked[63:32] : picked[31:0];
      default:   data_word = '0;
    endcase
  end

  always_comb begin
    unique case (port)
      PORT_SEL:  next_word = {{(WORD_W-SEL_W){1'b0}}, sel_q};
      PORT_DATA: next_word = data_word;
      default:   next_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_take;
      if (rd_take) rd_data <= next_word;
    end
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24,
  parameter int unsigned ADDR_W      = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_valid,
  input  logic                       bus_write,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic                       bus_ready,
  output logic                       rd_valid,
  output logic [31:0]                rd_data,
  output logic [64*NUM_ENTRIES-1:0]  entry_out
);
  port_e                               port;
  target_e                             target;
  logic                                sel_wr_evt;
  logic                                data_wr_evt;
  logic                                rd_take_evt;
  logic                                entry_wr_evt;
  logic [SEL_W-1:0]                    cur_sel;
  logic [7:0]                          ident_q;
  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] entries;

  assign bus_ready = 1'b1;

  irq_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .port      (port),
    .sel_wr    (sel_wr_evt),
    .data_wr   (data_wr_evt),
    .rd_take   (rd_take_evt)
  );

  irq_ctrl_regs #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_wr  (sel_wr_evt),
    .data_wr (data_wr_evt),
    .wdata   (bus_wdata),
    .sel_q   (cur_sel),
    .ident_q (ident_q),
    .target  (target)
  );

  assign entry_wr_evt = data_wr_evt && (target == TGT_ENTRY);

  irq_entry_bank #(.NUM_ENTRIES(NUM_ENTRIES)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (entry_wr_evt),
    .slot    (slot_of(cur_sel)),
    .upper   (upper_half(cur_sel)),
    .wdata   (bus_wdata),
    .entries (entries)
  );

  irq_readback #(.NUM_ENTRIES(NUM_ENTRIES)) u_read (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_take  (rd_take_evt),
    .port     (port),
    .target   (target),
    .sel_q    (cur_sel),
    .ident_q  (ident_q),
    .entries  (entries),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign entry_out = entries;
endmodule

// File: rtl/irq_route_checker.sv
module irq_route_checker #(
  parameter int unsigned NUM_ENTRIES = 24,
  parameter int unsigned ADDR_W      = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_valid,
  input logic                      bus_write,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_ready,
  input logic                      rd_valid,
  input logic [31:0]               rd_data,
  input logic [64*NUM_ENTRIES-1:0] entry_out,
  input logic [7:0]                cur_sel,
  input logic                      data_wr_evt
);
  logic rd_acc, at_data, at_other, sel_unmapped;
  logic [31:0] rev_exp;

  assign rd_acc   = bus_valid && bus_ready && !bus_write;
  assign at_data  = (bus_addr == ADDR_W'(16));
  assign at_other = (bus_addr != '0) && !at_data;
  assign sel_unmapped = ((cur_sel > 8'd1) && (cur_sel < 8'd16)) ||
                        (int'(cur_sel) >= 16 + 2 * int'(NUM_ENTRIES));
  assign rev_exp = (32'(NUM_ENTRIES - 1) << 16) | 32'h11;

  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rd_valid);

  p_read_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rd_valid);

  p_revision_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && at_data && cur_sel == 8'h01) |=> (rd_data == rev_exp));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && at_data && sel_unmapped) |=> (rd_data == 32'h0));

  p_stray_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && at_other) |=> (rd_data == 32'h0));

  p_unmapped_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_evt && sel_unmapped) |=> $stable(entry_out));

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_half
    p_keep_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr_evt && cur_sel == 8'(16 + 2 * e)) |=> $stable(entry_out[64*e+32 +: 32]));
    p_keep_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr_evt && cur_sel == 8'(17 + 2 * e)) |=> $stable(entry_out[64*e +: 32]));
  end
endmodule

bind irq_route_regs irq_route_checker #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .ADDR_W(ADDR_W)
) u_route_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_addr    (bus_addr),
  .bus_ready   (bus_ready),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .entry_out   (entry_out),
  .cur_sel     (cur_sel),
  .data_wr_evt (data_wr_evt)
);

// File: tb/test_irq_route_regs.sv
`timescale 1ns/1ps
module test_irq_route_regs;
  localparam int NE = 24;
  localparam logic [11:0] A_SEL  = 12'h000;
  localparam logic [11:0] A_DATA = 12'h010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0;
  logic bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, rd_valid;
  logic [31:0] rd_data;
  logic [64*NE-1:0] entry_out;

  int checks = 0;
  int fails = 0;

  logic [63:0] m_ent [NE];
  logic [7:0]  m_id;
  logic [7:0]  m_sel;

  always #2.5 clk = ~clk;

  irq_route_regs i_irq_route_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .entry_out(entry_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_data(input logic [7:0] s);
    int n;
    if (s == 8'h00) return {m_id, 24'h0};
    if (s == 8'h01) return 32'h11 | (32'(NE - 1) << 16);
    if (s < 8'h10) return 32'h0;
    n = (int'(s) - 16) / 2;
    if (n >= NE) return 32'h0;
    return s[0] ? m_ent[n][63:32] : m_ent[n][31:0];
  endfunction

  function automatic void model_data_wr(input logic [31:0] d);
    int n;
    if (m_sel == 8'h00) m_id = d[31:24];
    else if (m_sel >= 8'h10) begin
      n = (int'(m_sel) - 16) / 2;
      if (n < NE) begin
        if (m_sel[0]) m_ent[n][63:32] = d;
        else          m_ent[n][31:0]  = d;
      end
    end
  endfunction

  task automatic chk_table(input string req);
    int bad;
    bad = -1;
    for (int e = NE - 1; e >= 0; e--)
      if (entry_out[64*e +: 64] !== m_ent[e]) bad = e;
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s entry %0d actual=%h expected=%h", req, bad,
               entry_out[64*bad +: 64], m_ent[bad]);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    if (a == A_SEL) m_sel = d[7:0];
    else if (a == A_DATA) model_data_wr(d);
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    checks++;
    if (rd_valid !== 1'b1) begin
      fails++;
      $display("FAIL R2 rd_valid actual=%b expected=1", rd_valid);
    end
    d = rd_data;
  endtask

  task automatic rd_data_port(input string req);
    logic [31:0] v;
    bus_rd(A_DATA, v);
    chk(req, v, exp_data(m_sel));
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    for (int e = 0; e < NE; e++) m_ent[e] = 64'h0000_0000_0001_0000;
    m_id = '0; m_sel = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset values
    chk_table("R7 reset table");
    bus_rd(A_SEL, v);      chk("R7 R1 selector reset", v, 32'h0);
    rd_data_port("R7 ident reset");
    @(negedge clk);
    chk("R2 no rd_valid when idle", {31'h0, rd_valid}, 32'h0);

    // R1 selector write/read
    bus_wr(A_SEL, 32'hFFFF_FF37);
    chk("R2 no rd_valid after write", {31'h0, rd_valid}, 32'h0);
    bus_rd(A_SEL, v);      chk("R1 selector readback", v, 32'h37);

    // R3 ident
    bus_wr(A_SEL, 32'h0);
    bus_wr(A_DATA, 32'hA5C3_1234);
    rd_data_port("R3 ident");

    // R4 revision read-only
    bus_wr(A_SEL, 32'h1);
    rd_data_port("R4 revision");
    bus_wr(A_DATA, 32'hFFFF_FFFF);
    bus_rd(A_DATA, v);     chk("R4 revision after write", v, 32'h0017_0011);

    // R5 / R6 half writes on entry 0 and last entry
    bus_wr(A_SEL, 32'h10); bus_wr(A_DATA, 32'hDEAD_BEEF);
    bus_wr(A_SEL, 32'h11); bus_wr(A_DATA, 32'h0123_4567);
    bus_rd(A_DATA, v);     chk("R5 entry0 upper", v, 32'h0123_4567);
    bus_wr(A_SEL, 32'h10);
    bus_rd(A_DATA, v);     chk("R6 entry0 lower kept", v, 32'hDEAD_BEEF);
    bus_wr(A_SEL, 32'h3F); bus_wr(A_DATA, 32'hCAFE_F00D);
    rd_data_port("R5 last entry upper");
    bus_wr(A_SEL, 32'h3E);
    bus_rd(A_DATA, v);     chk("R6 last entry lower kept", v, 32'h0001_0000);
    chk_table("R10 R6 table after half writes");

    // R8 unmapped selectors
    bus_wr(A_SEL, 32'h40); bus_wr(A_DATA, 32'h5555_AAAA);
    rd_data_port("R8 selector 0x40 reads zero");
    chk_table("R8 table untouched by 0x40");
    bus_wr(A_SEL, 32'h05); bus_wr(A_DATA, 32'h7777_7777);
    rd_data_port("R8 selector 0x05 reads zero");
    bus_wr(A_SEL, 32'h0);
    rd_data_port("R8 ident untouched");

    // R9 stray offsets
    bus_wr(A_SEL, 32'h12);
    bus_wr(12'h004, 32'h0000_0099);
    bus_wr(12'hFFC, 32'h1111_2222);
    bus_rd(12'h004, v);    chk("R9 stray offset reads zero", v, 32'h0);
    bus_rd(12'h014, v);    chk("R9 offset 0x14 reads zero", v, 32'h0);
    bus_rd(A_SEL, v);      chk("R9 selector unchanged", v, 32'h12);
    chk_table("R9 table unchanged");

    // random rounds
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [7:0] s;
      r = int'($urandom % 8);
      if (r < 5)       s = 8'(16 + ($urandom % (2 * NE)));
      else if (r == 5) s = 8'($urandom % 2);
      else             s = 8'($urandom);
      bus_wr(A_SEL, {24'h0, s});
      if ($urandom % 3 != 0) bus_wr(A_DATA, $urandom);
      rd_data_port("R5 R6 R8 random data port");
      if (i % 20 == 0) chk_table("R10 random table");
    end
    chk_table("R10 final table");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule